// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block watches the destination address at the head of each incoming frame and decides whether the frame should be kept. Bytes arrive one per valid cycle, in wire order, with a start marker on the first byte. After the sixth address byte the block raises a one-clock decision strobe. The strobe carries four results: accept or reject, a flag for a group (multicast or broadcast) address, and the 6-bit hash index formed from the address.

The address is sorted into one of three kinds. Broadcast is all ones. Multicast is any other address whose first byte has its lowest bit set. Unicast is everything else. Three mode inputs control what is accepted: a promiscuous mode that keeps every frame, an enable for broadcast, and an enable for multicast. A multicast address is kept only if it also hits a 64-bit hash mask. The hash comes from a CRC-32 that runs over the address bits as they arrive, one byte per clock through an unrolled step. A unicast address is kept only if it equals the programmed station address.

The station address, the hash mask and the mode inputs come from outside the block. They must stay stable while an address is arriving.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: When `cfg_promisc` is 1 at the clock that samples the sixth address byte, the decision is accept, whatever the address.
- R2: An address whose six bytes are all 0xFF is broadcast. With promiscuous mode off it is accepted exactly when `cfg_bcast_en` is 1, and its group flag is 1.
- R3: An address that is not broadcast and whose first byte has bit 0 set is multicast. With promiscuous mode off it needs both `cfg_mcast_en` = 1 and a hash-mask hit to be accepted. Its group flag is 1.
- R4: The hash is a CRC register preset to all ones. It takes the address bits in order: byte 0 first, and within each byte bit 0 first. For each bit, the feedback is the register MSB XOR the data bit. The register shifts left by one, then is XORed with 0x04C11DB7 when the feedback is 1. `dec_hash` is bits 31..26 of the result, reported for every address kind.
- R5: The mask bit tested is `hash_mask[idx]`, where idx is the hash value. This is bit (idx mod 8) of mask byte (idx / 8), with byte k held in bits 8k+7..8k.
- R6: Any other address is unicast. Its group flag is 0. With promiscuous mode off it is accepted only if every byte equals the station address, where byte k of the station address is `station_addr[8k+7:8k]` and byte 0 is the first byte on the wire.
- R7: A byte with `rx_valid` and `rx_sof` both high is address byte 0. Later bytes count only on `rx_valid` cycles, so idle gaps are allowed. Bytes after the sixth, and bytes with no preceding start, are ignored. A new start in the middle of an address restarts the count.
- R8: `dec_valid` pulses for exactly one clock, in the clock after the edge that samples the sixth address byte. The other decision outputs keep their values between pulses.
- R9: After reset, `dec_valid`, `dec_accept`, `dec_group` and `dec_hash` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte on `rx_data` is valid this cycle |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_data | input | DATA_W (8) | Received byte |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_en | input | 1 | Allow broadcast frames |
| cfg_mcast_en | input | 1 | Allow multicast frames that hit the hash mask |
| station_addr | input | DATA_W*ADDR_BYTES (48) | Own unicast address, byte 0 in the low bits |
| hash_mask | input | 2**HASH_W (64) | Multicast hash mask |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | 1 = keep the frame |
| dec_group | output | 1 | Destination is a group address |
| dec_hash | output | HASH_W (6) | Hash index of the destination address |

## Verification
A single-bit mask is swept over all 64 positions against random multicast addresses. Each frame must be accepted exactly when the software CRC index matches the swept bit, which separates errors in the hash arithmetic from errors in mask addressing. All eight combinations of the mode inputs are applied to broadcast, multicast, matching unicast and non-matching unicast addresses; this separates mode precedence from classification. Single-byte mismatches at each station byte position show that every byte is compared. Framing stimuli cover idle gaps, trailing bytes, bytes with no start marker and a restart in the middle of an address, and show whether the strobe is tied to the right byte.

// File: rtl/eth_filt_pkg.sv
package eth_filt_pkg;

   typedef enum logic [1:0] {
      CLS_UNICAST   = 2'd0,
      CLS_MULTICAST = 2'd1,
      CLS_BROADCAST = 2'd2
   } addr_class_e;

   typedef struct packed {
      logic all_ones;
      logic station_eq;
      logic group;
   } addr_flags_t;

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
   parameter int              DATA_W = 8,
   parameter int              CRC_W  = 32,
   parameter logic [CRC_W-1:0] POLY  = 32'h04C11DB7
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc_out
);

   logic [DATA_W:0][CRC_W-1:0] stage;

   assign stage[0] = crc_in;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic fb;
      assign fb = stage[b][CRC_W-1] ^ data[b];
      assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[DATA_W];

endmodule

// File: rtl/addr_tracker.sv
module addr_tracker
   import eth_filt_pkg::*;
#(
   parameter int              DATA_W     = 8,
   parameter int              ADDR_BYTES = 6,
   parameter int              CRC_W      = 32,
   parameter int              HASH_W     = 6,
   parameter logic [CRC_W-1:0] POLY      = 32'h04C11DB7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rx_valid,
   input  logic                         rx_sof,
   input  logic [DATA_W-1:0]            rx_data,
   input  logic [DATA_W*ADDR_BYTES-1:0] station_addr,
   output logic                         last_hit,
   output logic [HASH_W-1:0]            hash_now,
   output addr_flags_t                  flags_now
);

   localparam int CNT_W = $clog2(ADDR_BYTES + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  pos;
   logic [CRC_W-1:0]  crc_q, crc_base, crc_now;
   addr_flags_t       flags_q;
   logic              take;
   logic [DATA_W-1:0] st_byte [ADDR_BYTES];

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_stb
      assign st_byte[k] = station_addr[k*DATA_W +: DATA_W];
   end

   assign take     = rx_valid && (rx_sof || (cnt_q != '0 && cnt_q < CNT_W'(ADDR_BYTES)));
   assign pos      = rx_sof ? '0 : cnt_q;
   assign crc_base = rx_sof ? '1 : crc_q;
   assign last_hit = take && (pos == CNT_W'(ADDR_BYTES - 1));
   assign hash_now = crc_now[CRC_W-1 -: HASH_W];

   crc_byte_step #(
      .DATA_W (DATA_W),
      .CRC_W  (CRC_W),
      .POLY   (POLY)
   ) i_crc_step (
      .crc_in  (crc_base),
      .data    (rx_data),
      .crc_out (crc_now)
   );

   always_comb begin
      flags_now.all_ones   = (rx_sof | flags_q.all_ones) & (&rx_data);
      flags_now.station_eq = (rx_sof | flags_q.station_eq) & (rx_data == st_byte[pos]);
      flags_now.group      = rx_sof ? rx_data[0] : flags_q.group;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         crc_q   <= '1;
         flags_q <= '0;
      end else if (take) begin
         cnt_q   <= pos + CNT_W'(1);
         crc_q   <= crc_now;
         flags_q <= flags_now;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(cnt_q) && $stable(crc_q)); // R7

endmodule

// File: rtl/rx_accept_decide.sv
module rx_accept_decide
   import eth_filt_pkg::*;
#(
   parameter int HASH_W = 6,
   parameter int MASK_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              last_hit,
   input  logic [HASH_W-1:0] hash_now,
   input  addr_flags_t       flags_now,
   input  logic              cfg_promisc,
   input  logic              cfg_bcast_en,
   input  logic              cfg_mcast_en,
   input  logic [MASK_W-1:0] hash_mask,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic              dec_group,
   output logic [HASH_W-1:0] dec_hash
);

   addr_class_e cls;
   logic        keep;

   always_comb begin
      if (flags_now.all_ones)   cls = CLS_BROADCAST;
      else if (flags_now.group) cls = CLS_MULTICAST;
      else                      cls = CLS_UNICAST;

      unique case (cls)
         CLS_BROADCAST: keep = cfg_bcast_en;
         CLS_MULTICAST: keep = cfg_mcast_en & hash_mask[hash_now];
         default:       keep = flags_now.station_eq;
      endcase
      keep = keep | cfg_promisc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_group  <= 1'b0;
         dec_hash   <= '0;
      end else begin
         dec_valid <= last_hit;
         if (last_hit) begin
            dec_accept <= keep;
            dec_group  <= flags_now.group;
            dec_hash   <= hash_now;
         end
      end
   end

   AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && $past(cfg_promisc) |-> dec_accept); // R1

   AST_GROUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_group && !$past(cfg_promisc) && !$past(cfg_bcast_en)
      && !$past(cfg_mcast_en) |-> !dec_accept); // R3

   AST_HASH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid && dec_group && !$past(cfg_promisc) && !$past(cfg_bcast_en)
      && $stable(hash_mask) && !hash_mask[dec_hash] |-> !dec_accept); // R5

   AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid); // R8

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
   import eth_filt_pkg::*;
#(
   parameter int              DATA_W     = 8,
   parameter int              ADDR_BYTES = 6,
   parameter int              CRC_W      = 32,
   parameter int              HASH_W     = 6,
   parameter logic [CRC_W-1:0] CRC_POLY  = 32'h04C11DB7,
   localparam int             ADDR_W     = DATA_W * ADDR_BYTES,
   localparam int             MASK_W     = 1 << HASH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              cfg_promisc,
   input  logic              cfg_bcast_en,
   input  logic              cfg_mcast_en,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic [MASK_W-1:0] hash_mask,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic              dec_group,
   output logic [HASH_W-1:0] dec_hash
);

   if (HASH_W < 1 || HASH_W > CRC_W) begin : g_bad_hash
      $error("HASH_W must lie in 1..CRC_W");
   end
   if (ADDR_BYTES < 2) begin : g_bad_len
      $error("ADDR_BYTES must be at least 2");
   end
   if (CRC_W < 2 || DATA_W < 1) begin : g_bad_width
      $error("CRC_W must be at least 2 and DATA_W at least 1");
   end

   logic              last_hit;
   logic [HASH_W-1:0] hash_now;
   addr_flags_t       flags_now;

   addr_tracker #(
      .DATA_W     (DATA_W),
      .ADDR_BYTES (ADDR_BYTES),
      .CRC_W      (CRC_W),
      .HASH_W     (HASH_W),
      .POLY       (CRC_POLY)
   ) i_tracker (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid     (rx_valid),
      .rx_sof       (rx_sof),
      .rx_data      (rx_data),
      .station_addr (station_addr),
      .last_hit     (last_hit),
      .hash_now     (hash_now),
      .flags_now    (flags_now)
   );

   rx_accept_decide #(
      .HASH_W (HASH_W),
      .MASK_W (MASK_W)
   ) i_decide (
      .clk          (clk),
      .rst_n        (rst_n),
      .last_hit     (last_hit),
      .hash_now     (hash_now),
      .flags_now    (flags_now),
      .cfg_promisc  (cfg_promisc),
      .cfg_bcast_en (cfg_bcast_en),
      .cfg_mcast_en (cfg_mcast_en),
      .hash_mask    (hash_mask),
      .dec_valid    (dec_valid),
      .dec_accept   (dec_accept),
      .dec_group    (dec_group),
      .dec_hash     (dec_hash)
   );

   AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(rx_valid)); // R8

endmodule

// File: tb/test_eth_rx_addr_filter.sv
`timescale 1ns/1ps
module test_eth_rx_addr_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic        rx_sof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        cfg_promisc = 1'b0;
   logic        cfg_bcast_en = 1'b0;
   logic        cfg_mcast_en = 1'b0;
   logic [47:0] station_addr = '0;
   logic [63:0] hash_mask = '0;
   logic        dec_valid, dec_accept, dec_group;
   logic [5:0]  dec_hash;

   int n_chk = 0;
   int n_bad = 0;
   int strobes;
   logic       cap_acc, cap_grp;
   logic [5:0] cap_hash;

   always #4 clk = ~clk;

   eth_rx_addr_filter i_eth_rx_addr_filter (
      .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_sof (rx_sof),
      .rx_data (rx_data), .cfg_promisc (cfg_promisc), .cfg_bcast_en (cfg_bcast_en),
      .cfg_mcast_en (cfg_mcast_en), .station_addr (station_addr), .hash_mask (hash_mask),
      .dec_valid (dec_valid), .dec_accept (dec_accept), .dec_group (dec_group),
      .dec_hash (dec_hash)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] sw_hash(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         logic fb = c[31] ^ a[i];
         c = c << 1;
         if (fb) c = c ^ 32'h04C1_1DB7;
      end
      return c[31:26];
   endfunction

   function automatic logic exp_acc(input logic [47:0] a);
      if (cfg_promisc) return 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) return cfg_bcast_en;
      if (a[0]) return cfg_mcast_en & hash_mask[sw_hash(a)];
      return a == station_addr;
   endfunction

   function automatic logic [47:0] rnd_mcast();
      logic [47:0] a = {$urandom, $urandom};
      a[0] = 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) a[1] = 1'b0;
      return a;
   endfunction

   task automatic sample();
      if (dec_valid) begin
         strobes++;
         cap_acc  = dec_accept;
         cap_grp  = dec_group;
         cap_hash = dec_hash;
      end
   endtask

   task automatic send(input logic [47:0] a, input int nbytes, input bit sof_first, input bit gaps);
      for (int i = 0; i < nbytes; i++) begin
         if (gaps) begin
            @(negedge clk); sample(); rx_valid = 1'b0; rx_sof = 1'b0;
         end
         @(negedge clk); sample();
         rx_valid = 1'b1;
         rx_sof   = sof_first && (i == 0);
         rx_data  = (i < 6) ? a[8*i +: 8] : 8'($urandom);
      end
   endtask

   task automatic finish_idle();
      repeat (3) begin
         @(negedge clk); sample(); rx_valid = 1'b0; rx_sof = 1'b0;
      end
   endtask

   task automatic frame(input logic [47:0] a, input int extra, input bit gaps, input string req);
      strobes = 0;
      send(a, 6 + extra, 1'b1, gaps);
      finish_idle();
      chk({req, " R8 one strobe"}, strobes, 1);
      chk({req, " accept"}, cap_acc, exp_acc(a));
      chk({req, " R3 group flag"}, cap_grp, a[0]);
      chk({req, " R4 hash"}, cap_hash, sw_hash(a));
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [47:0] a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 valid", dec_valid, 0);
      chk("R9 accept", dec_accept, 0);
      chk("R9 group", dec_group, 0);
      chk("R9 hash", dec_hash, 0);

      // R7 bytes without a start marker are ignored
      strobes = 0;
      send(48'h0123_4567_89AB, 10, 1'b0, 1'b0);
      finish_idle();
      chk("R7 no start no strobe", strobes, 0);

      station_addr = {$urandom, $urandom};
      station_addr[0] = 1'b0;

      // R4 R5 single-bit mask sweep over all hash positions
      cfg_mcast_en = 1'b1;
      for (int k = 0; k < 64; k++) begin
         hash_mask = 64'd1 << k;
         for (int j = 0; j < 4; j++) frame(rnd_mcast(), 0, 1'b0, "R5 sweep");
      end

      // R3 R4 random masks, random multicast
      for (int j = 0; j < 200; j++) begin
         hash_mask = {$urandom, $urandom};
         frame(rnd_mcast(), 0, j[0], "R3 random");
      end

      // R1 R2 R3 R6 all mode combinations against each address kind
      for (int m = 0; m < 8; m++) begin
         cfg_promisc  = m[2];
         cfg_mcast_en = m[1];
         cfg_bcast_en = m[0];
         for (int j = 0; j < 6; j++) begin
            hash_mask = {$urandom, $urandom};
            frame(48'hFFFF_FFFF_FFFF, 0, 1'b0, "R2 broadcast");
            frame(rnd_mcast(), 0, 1'b0, "R3 multicast");
            frame(station_addr, 0, 1'b0, "R6 station match");
            a = {$urandom, $urandom}; a[0] = 1'b0;
            frame(a, 0, 1'b0, "R1 unicast other");
         end
      end

      // R6 single-byte mismatch at each position
      cfg_promisc = 1'b0; cfg_bcast_en = 1'b1; cfg_mcast_en = 1'b1;
      for (int p = 0; p < 6; p++) begin
         a = station_addr;
         a[8*p + 1] = ~a[8*p + 1];
         frame(a, 0, 1'b0, "R6 byte mismatch");
      end

      // R7 R8 idle gaps and trailing bytes
      frame(station_addr, 4, 1'b1, "R7 gaps trailing");
      frame(48'hFFFF_FFFF_FFFF, 9, 1'b0, "R7 trailing bcast");

      // R7 restart in the middle of an address
      strobes = 0;
      send(48'hFFFF_FFFF_FFFF, 3, 1'b1, 1'b0);
      send(station_addr, 6, 1'b1, 1'b0);
      finish_idle();
      chk("R7 restart one strobe", strobes, 1);
      chk("R7 restart accept", cap_acc, 1);
      chk("R7 restart group", cap_grp, 0);
      chk("R7 restart hash", cap_hash, sw_hash(station_addr));

      // R8 outputs hold after the strobe
      chk("R8 hold accept", dec_accept, 1);
      chk("R8 hold hash", dec_hash, sw_hash(station_addr));

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule